// File: doc/BRIEF.md
# Resolver Read Sequencer

This block sits on the host side of a parallel port that serves sampled angular position and angular velocity words. A single start request with a mode code makes it run a complete read transaction. It raises the sample strobe for a fixed width and then waits out the settling interval. It drives the position/velocity select line, and after a setup interval it pulls chip-select and read-strobe low together. Once the data-valid interval has passed it registers the bus and releases the strobes. It then keeps the read strobe high for a recovery interval before it reads again or reports completion.

In the combined mode, one sample strobe is followed by two reads: first position, then velocity. Completion is signalled only after the second word. Every interval is a parameter counted in system-clock cycles, and any value below one is raised to one. Results are held in a position register and a velocity register. Each register has a flag that says whether the last transaction refreshed it. Both registers and both flags change only in the cycle where the completion pulse is high.

Top module: `resolver_read_seq`

## Requirements
- R1: While reset is low and right after it is released: sample strobe 0, chip-select and read-strobe 1 (inactive), select 1, busy 0, done 0, both words 0, both fresh flags 0.
- R2: A start request seen in idle is accepted at that clock edge. From the next cycle, busy is 1 and the sample strobe is 1 for exactly SMP_CYC cycles.
- R3: After the sample strobe falls, read-strobe and chip-select stay high for at least S2R_CYC + SU_CYC cycles before the first read.
- R4: Select = 1 asks for position and 0 asks for velocity. It takes the first target at acceptance. It is held for at least SU_CYC cycles before read-strobe falls, for the whole low phase, and for the cycle after read-strobe rises.
- R5: For each read, chip-select and read-strobe fall and rise together and stay low for max(DV_CYC, HOLD_CYC) + 1 cycles. The bus is registered at the clock edge that ends the last low cycle.
- R6: After each read, read-strobe stays high for REC_CYC cycles before the next read or before completion.
- R7: The mode code is 2'b00 for velocity only and 2'b01 for position only. 2'b10 and 2'b11 both mean one sample strobe, then a position read, then a velocity read.
- R8: Done is a one-cycle pulse in the cycle after the last recovery, and busy is 0 in that cycle. The position and velocity words and their fresh flags take their new values in that same cycle. A word that was not read keeps its value with its flag at 0. No word or flag changes in any other cycle.
- R9: A start request that arrives while busy has no effect on the running transaction or its results. A start request in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| mode_i | input | 2 | Transaction kind (R7 encoding) |
| bus_i | input | DATA_W | Parallel data bus from the port |
| sample_o | output | 1 | Sample strobe, active high |
| cs_n_o | output | 1 | Chip-select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| pos_sel_o | output | 1 | 1 = position, 0 = velocity |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pos_word_o | output | DATA_W | Last committed position word |
| vel_word_o | output | DATA_W | Last committed velocity word |
| pos_fresh_o | output | 1 | Last transaction refreshed the position word |
| vel_fresh_o | output | 1 | Last transaction refreshed the velocity word |

## Verification
The bench plays the port itself. It latches fresh values on each sample strobe and drives the inverse of the wanted word until the read strobe has been low for the data-valid count. A design that captures too early, or that reads without sampling first, therefore returns the wrong words. Every mode is swept over sixteen data patterns, and each cycle of each transaction is compared with a strobe schedule worked out from the interval parameters. A strobe interval that is one cycle short, or a select that changes inside a read, shows up as a waveform mismatch. Some transactions also receive a start request in the middle with a different mode; a design that restarts or changes its target then completes at the wrong cycle or with the wrong flags. Back-to-back starts issued in the done cycle check that acceptance is not lost. The hold interval is set longer than the data-valid interval so that the longer of the two must set the read length.

// File: rtl/rrs_pkg.sv
// Shared types for the resolver read sequencer.
// Assumes: none; declarations only.
package rrs_pkg;

    // Sequencer states, one per timed interval plus idle and capture.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SMP_PULSE  = 3'd1,
        ST_SMP_WAIT   = 3'd2,
        ST_SETUP      = 3'd3,
        ST_READ_WAIT  = 3'd4,
        ST_CAPTURE    = 3'd5,
        ST_RECOVER    = 3'd6
    } rrs_state_e;

    // Mode codes: bit 1 set selects the combined read.
    localparam logic [1:0] MODE_VEL = 2'b00;
    localparam logic [1:0] MODE_POS = 2'b01;

endpackage

// File: rtl/rrs_timer.sv
// Interval down-counter for the sequencer.
// Loads a value on request and counts down to zero, then holds.
// Assumes: the load value is the interval length minus one.
module rrs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, else decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rrs_fsm.sv
// Transaction state machine for the resolver read sequencer.
// Steps through sample pulse, settle, select setup, read, capture and
// recovery; repeats setup..recovery once for the combined mode.
// Assumes: every length parameter is already at least one.
module rrs_fsm
    import rrs_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SMP_LEN = 1,
    parameter int S2R_LEN = 1,
    parameter int SU_LEN  = 1,
    parameter int RD_LEN  = 1,
    parameter int REC_LEN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             tmr_zero_i,
    output rrs_state_e       state_o,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             commit_o,
    output logic             sel_o,
    output logic             done_o
);

    rrs_state_e state_q, state_d;
    logic       sel_q;
    logic       second_q;
    logic       done_q;
    logic       last_rec;

    assign last_rec = (state_q == ST_RECOVER) && tmr_zero_i;

    // Next state and timer load for the current interval.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o   = 1'b1;
                    state_d    = ST_SMP_PULSE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(SMP_LEN - 1);
                end
            end
            ST_SMP_PULSE: begin
                if (tmr_zero_i) begin
                    state_d    = ST_SMP_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(S2R_LEN - 1);
                end
            end
            ST_SMP_WAIT: begin
                if (tmr_zero_i) begin
                    state_d    = ST_SETUP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(SU_LEN - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) begin
                    state_d    = ST_READ_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(RD_LEN - 1);
                end
            end
            ST_READ_WAIT: begin
                if (tmr_zero_i) begin
                    state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                capture_o  = 1'b1;
                state_d    = ST_RECOVER;
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(REC_LEN - 1);
            end
            ST_RECOVER: begin
                if (tmr_zero_i) begin
                    if (second_q) begin
                        state_d    = ST_SETUP;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = CNT_W'(SU_LEN - 1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Select line and pending second read; select is set at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b1;
            second_q <= 1'b0;
        end else if (accept_o) begin
            sel_q    <= (mode_i != MODE_VEL);
            second_q <= mode_i[1];
        end else if (last_rec && second_q) begin
            sel_q    <= 1'b0;
            second_q <= 1'b0;
        end
    end

    // Completion pulse after the final recovery interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_rec && !second_q;
        end
    end

    assign commit_o = last_rec && !second_q;
    assign state_o  = state_q;
    assign sel_o    = sel_q;
    assign done_o   = done_q;

endmodule

// File: rtl/rrs_capture.sv
// Result staging and commit for the resolver read sequencer.
// Captured words wait in staging registers and reach the outputs only
// on commit, so the outputs change once per transaction.
// Assumes: clear and capture never coincide; commit follows all captures.
module rrs_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic              cap_pos_i,
    input  logic [DATA_W-1:0] bus_i,
    input  logic              commit_i,
    output logic [DATA_W-1:0] pos_word_o,
    output logic [DATA_W-1:0] vel_word_o,
    output logic              pos_fresh_o,
    output logic              vel_fresh_o
);

    logic [DATA_W-1:0] pos_stage_q, vel_stage_q;
    logic              pos_got_q, vel_got_q;

    // Staging: clear the got-flags at acceptance, fill on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_stage_q <= '0;
            vel_stage_q <= '0;
            pos_got_q   <= 1'b0;
            vel_got_q   <= 1'b0;
        end else if (clear_i) begin
            pos_got_q <= 1'b0;
            vel_got_q <= 1'b0;
        end else if (capture_i) begin
            if (cap_pos_i) begin
                pos_stage_q <= bus_i;
                pos_got_q   <= 1'b1;
            end else begin
                vel_stage_q <= bus_i;
                vel_got_q   <= 1'b1;
            end
        end
    end

    // Output registers: refreshed words and flags appear on commit only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_word_o  <= '0;
            vel_word_o  <= '0;
            pos_fresh_o <= 1'b0;
            vel_fresh_o <= 1'b0;
        end else if (commit_i) begin
            if (pos_got_q) begin
                pos_word_o <= pos_stage_q;
            end
            if (vel_got_q) begin
                vel_word_o <= vel_stage_q;
            end
            pos_fresh_o <= pos_got_q;
            vel_fresh_o <= vel_got_q;
        end
    end

endmodule

// File: rtl/resolver_read_seq.sv
// Host-side read sequencer for a sampled position/velocity port.
// Runs sample strobe, settle, select setup, strobed read and recovery,
// with every interval a parameter in system-clock cycles (minimum 1).
// Assumes: bus_i is valid DV_CYC cycles after the strobes fall.
module resolver_read_seq
    import rrs_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int SMP_CYC  = 35,
    parameter int S2R_CYC  = 100,
    parameter int SU_CYC   = 1,
    parameter int DV_CYC   = 3,
    parameter int HOLD_CYC = 1,
    parameter int REC_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              sample_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              pos_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] pos_word_o,
    output logic [DATA_W-1:0] vel_word_o,
    output logic              pos_fresh_o,
    output logic              vel_fresh_o
);

    localparam int SMP_LEN = (SMP_CYC < 1) ? 1 : SMP_CYC;
    localparam int S2R_LEN = (S2R_CYC < 1) ? 1 : S2R_CYC;
    localparam int SU_LEN  = (SU_CYC  < 1) ? 1 : SU_CYC;
    localparam int DV_LEN  = (DV_CYC  < 1) ? 1 : DV_CYC;
    localparam int HD_LEN  = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int REC_LEN = (REC_CYC < 1) ? 1 : REC_CYC;
    localparam int RD_LEN  = (DV_LEN > HD_LEN) ? DV_LEN : HD_LEN;
    localparam int MAX_A   = (SMP_LEN > S2R_LEN) ? SMP_LEN : S2R_LEN;
    localparam int MAX_B   = (SU_LEN > RD_LEN) ? SU_LEN : RD_LEN;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN = (MAX_C > REC_LEN) ? MAX_C : REC_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    rrs_state_e       state;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture, commit, sel;
    logic             strobe_low;

    rrs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rrs_fsm #(
        .CNT_W   (CNT_W),
        .SMP_LEN (SMP_LEN),
        .S2R_LEN (S2R_LEN),
        .SU_LEN  (SU_LEN),
        .RD_LEN  (RD_LEN),
        .REC_LEN (REC_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .tmr_zero_i (tmr_zero),
        .state_o    (state),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .accept_o   (accept),
        .capture_o  (capture),
        .commit_o   (commit),
        .sel_o      (sel),
        .done_o     (done_o)
    );

    rrs_capture #(.DATA_W(DATA_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .capture_i   (capture),
        .cap_pos_i   (sel),
        .bus_i       (bus_i),
        .commit_i    (commit),
        .pos_word_o  (pos_word_o),
        .vel_word_o  (vel_word_o),
        .pos_fresh_o (pos_fresh_o),
        .vel_fresh_o (vel_fresh_o)
    );

    // Port strobes decoded from the registered state.
    always_comb begin
        strobe_low = (state == ST_READ_WAIT) || (state == ST_CAPTURE);
        sample_o   = (state == ST_SMP_PULSE);
        cs_n_o     = !strobe_low;
        rd_n_o     = !strobe_low;
        busy_o     = (state != ST_IDLE);
        pos_sel_o  = sel;
    end

endmodule

// File: rtl/rrs_checker.sv
// Protocol checker for the resolver read sequencer, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module rrs_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sample_o,
    input logic              cs_n_o,
    input logic              rd_n_o,
    input logic              pos_sel_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] pos_word_o,
    input logic [DATA_W-1:0] vel_word_o,
    input logic              pos_fresh_o,
    input logic              vel_fresh_o
);

    // R1 / R2: an idle sequencer drives no strobe.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_n_o && cs_n_o && !sample_o));

    // R2: a sample strobe only begins straight after idle.
    p_sample_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> $past(!busy_o));

    // R3: never sample and read at once.
    p_sample_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (rd_n_o && cs_n_o));

    // R4: select is held as the strobe falls and while it is low.
    p_sel_held_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> $stable(pos_sel_o));

    // R4: select is held in the cycle the strobe rises.
    p_sel_held_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> $stable(pos_sel_o));

    // R5: chip-select and read-strobe move together.
    p_strobes_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o == rd_n_o);

    // R8: done is a single-cycle pulse with busy low.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // R8: results only move in the done cycle.
    p_results_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pos_word_o) && $stable(vel_word_o)
                     && $stable(pos_fresh_o) && $stable(vel_fresh_o)));

    // R9: a start request while busy does not end the transaction.
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

bind resolver_read_seq rrs_checker #(.DATA_W(DATA_W)) u_rrs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sample_o    (sample_o),
    .cs_n_o      (cs_n_o),
    .rd_n_o      (rd_n_o),
    .pos_sel_o   (pos_sel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pos_word_o  (pos_word_o),
    .vel_word_o  (vel_word_o),
    .pos_fresh_o (pos_fresh_o),
    .vel_fresh_o (vel_fresh_o)
);

// File: tb/test_resolver_read_seq.sv
// Bench for the resolver read sequencer: a port model plus a sweep of all
// modes over data patterns, with a cycle-exact expected strobe schedule.
module test_resolver_read_seq;

    localparam int DW     = 12;
    localparam int SMP    = 2;
    localparam int S2R    = 3;
    localparam int SU     = 2;
    localparam int DV     = 2;
    localparam int HOLD   = 3;
    localparam int REC    = 2;
    localparam int RD_LOW = ((DV > HOLD) ? DV : HOLD) + 1;
    localparam int RBLK   = SU + RD_LOW + REC;
    localparam int PRE    = SMP + S2R;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [DW-1:0] bus;
    logic          sample, cs_n, rd_n, pos_sel, busy, done;
    logic [DW-1:0] pos_word, vel_word;
    logic          pos_fresh, vel_fresh;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    resolver_read_seq #(
        .DATA_W(DW), .SMP_CYC(SMP), .S2R_CYC(S2R), .SU_CYC(SU),
        .DV_CYC(DV), .HOLD_CYC(HOLD), .REC_CYC(REC)
    ) i_resolver_read_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .bus_i(bus), .sample_o(sample), .cs_n_o(cs_n), .rd_n_o(rd_n),
        .pos_sel_o(pos_sel), .busy_o(busy), .done_o(done),
        .pos_word_o(pos_word), .vel_word_o(vel_word),
        .pos_fresh_o(pos_fresh), .vel_fresh_o(vel_fresh)
    );

    always #4 clk = ~clk;

    // Port model: latch on the sample strobe, serve after DV low cycles.
    logic [DW-1:0] live_pos = '0, live_vel = '0;
    logic [DW-1:0] lat_pos = '0, lat_vel = '0;
    logic          smp_prev = 1'b0;
    int            rd_cnt = 0;

    always @(negedge clk) begin
        if (sample && !smp_prev) begin
            lat_pos <= live_pos;
            lat_vel <= live_vel;
        end
        smp_prev <= sample;
        if (!rd_n && !cs_n) rd_cnt <= rd_cnt + 1;
        else                rd_cnt <= 0;
    end

    assign bus = (!cs_n && !rd_n && rd_cnt >= DV) ?
                 (pos_sel ? lat_pos : lat_vel) :
                 ~(pos_sel ? lat_pos : lat_vel);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected result state of the bench.
    logic [DW-1:0] e_pos = '0, e_vel = '0;
    bit            e_pf = 0, e_vf = 0;

    task automatic run(input logic [1:0] m, input logic [DW-1:0] pv,
                       input logic [DW-1:0] vv, input bit inject);
        int  nrd   = m[1] ? 2 : 1;
        bit  first = (m != 2'b00);
        bit  last  = (m == 2'b01);
        int  t_end = PRE + nrd * RBLK;
        int  err_smp = 0, err_strobe = 0, err_sel = 0, err_bd = 0, err_stab = 0;
        logic [DW-1:0] o_pos = e_pos, o_vel = e_vel;
        bit  o_pf = e_pf, o_vf = e_vf;
        live_pos = pv;
        live_vel = vv;
        start = 1'b1;
        mode  = m;
        for (int k = 0; k <= t_end; k++) begin
            bit x_smp, x_low, x_sel, x_busy, x_done;
            @(negedge clk);
            start = inject && (k == 3);
            mode  = inject ? ~m : m;
            if (k == t_end) begin
                x_smp = 0; x_low = 0; x_sel = last; x_busy = 0; x_done = 1;
            end else begin
                x_smp  = (k < SMP);
                x_busy = 1;
                x_done = 0;
                if (k < PRE) begin
                    x_low = 0;
                    x_sel = first;
                end else begin
                    int j = (k - PRE) / RBLK;
                    int o = (k - PRE) % RBLK;
                    x_low = (o >= SU) && (o < SU + RD_LOW);
                    x_sel = (j == 0) ? first : 1'b0;
                end
                if (pos_word !== o_pos || vel_word !== o_vel ||
                    pos_fresh !== o_pf || vel_fresh !== o_vf) err_stab++;
            end
            if (sample !== x_smp) err_smp++;
            if (rd_n !== !x_low || cs_n !== !x_low) err_strobe++;
            if (pos_sel !== x_sel) err_sel++;
            if (busy !== x_busy || done !== x_done) err_bd++;
        end
        start = 1'b0;
        mode  = m;
        if (m != 2'b00) begin e_pos = pv; e_pf = 1; end else e_pf = 0;
        if (m != 2'b01) begin e_vel = vv; e_vf = 1; end else e_vf = 0;
        check(err_smp == 0, "R2", "sample strobe cycles wrong", err_smp, 0);
        check(err_strobe == 0, "R3/R5/R6", "read strobe cycles wrong", err_strobe, 0);
        check(err_sel == 0, "R4", "select cycles wrong", err_sel, 0);
        check(err_bd == 0, "R8", "busy/done cycles wrong", err_bd, 0);
        check(err_stab == 0, "R8", "results moved before done", err_stab, 0);
        check(pos_word == e_pos, "R7", "position word", pos_word, e_pos);
        check(vel_word == e_vel, "R7", "velocity word", vel_word, e_vel);
        check({pos_fresh, vel_fresh} == {e_pf, e_vf}, "R7", "fresh flags",
              {pos_fresh, vel_fresh}, {e_pf, e_vf});
        if (inject) check(err_bd == 0 && err_sel == 0, "R9",
                          "start while busy disturbed transaction", err_bd + err_sel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check({sample, cs_n, rd_n, pos_sel, busy, done} == 6'b011100, "R1",
              "strobes in reset", {sample, cs_n, rd_n, pos_sel, busy, done}, 6'b011100);
        rst_n = 1'b1;
        @(negedge clk);
        check({sample, cs_n, rd_n, pos_sel, busy, done} == 6'b011100, "R1",
              "strobes after reset", {sample, cs_n, rd_n, pos_sel, busy, done}, 6'b011100);
        check(pos_word == 0 && vel_word == 0 && !pos_fresh && !vel_fresh, "R1",
              "results after reset", {pos_word, vel_word}, 0);
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [DW-1:0] pv = DW'(i * 273 + m * 57) ^ 12'h5A3;
                logic [DW-1:0] vv = ~DW'(i * 391 + m);
                run(2'(m), pv, vv, (i % 5) == 2);
            end
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule